// File: doc/BRIEF.md
# Clock Second-Chance Victim Selector

This block chooses which physical frame to evict when a new page must be brought in. It holds a single "recently used" flag per frame plus a circular hand index. Every access to a frame raises that frame's flag. When a replacement is requested, the block walks the frames one per cycle, starting at the hand. A frame whose flag is raised loses the flag and is passed over, so a recently used frame gets a second chance. The first frame met with a clear flag is handed back as the victim.

The surrounding memory manager drives the reference port on every frame access. It pulses the replace request when it needs a free frame, then waits for the one-cycle grant, which carries the victim index. A busy flag is high while the walk is in progress, and further requests are ignored until the grant. The victim is returned with its flag already raised, because the page loaded into it counts as just used.

Top module: `clock_victim_sel`

## Requirements
- R1: After reset every frame flag is clear, the hand is at frame 0, busy and grant are low and the victim output is 0. A first request therefore returns frame 0, with the grant one cycle after the request edge.
- R2: A reference with a frame index below the frame count raises that frame's flag at the next clock edge.
- R3: During a walk, a frame at the hand whose flag is raised has the flag cleared and is skipped.
- R4: The victim is the first frame in circular order from the hand whose flag was clear when it was examined.
- R5: The walk examines one frame per cycle. If k frames with raised flags are passed before the victim, the grant arrives k+1 cycles after the edge that accepted the request. The longest walk, with every flag raised, takes N+1 cycles for N frames and returns the frame the hand started on.
- R6: After a grant the hand holds the index after the victim, wrapping from frame N-1 to frame 0.
- R7: The victim's flag is raised in the same edge that issues the grant.
- R8: A reference to the frame whose flag the walk clears in the same cycle wins, and the flag stays raised.
- R9: A request accepted while idle raises busy from the next cycle until the decision. The grant is a single-cycle pulse with busy low. Requests seen while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_valid | input | 1 | A frame was accessed this cycle |
| ref_frame | input | IDX_W | Index of the accessed frame |
| repl_req | input | 1 | Request a victim frame |
| repl_busy | output | 1 | A victim walk is in progress |
| repl_grant | output | 1 | One-cycle pulse: victim_frame is valid |
| victim_frame | output | IDX_W | Index of the chosen victim |

## Verification
On every cycle the assertions check the following. A reference raises its frame's flag one edge later, even during a clearing walk. The grant is a lone pulse that never overlaps busy, and an idle request always starts a walk. A walk never runs past N+1 cycles. At each grant the victim's flag was clear when it was examined and is now raised, and the hand sits just after the victim. Only the bench's scenarios can show the rest. These are the exact victim chosen and the exact latency for every mix of flags and hand positions, and the effect of clearing on the next walk. They also show that a request made while busy never produces a second grant.

// File: rtl/cvs_pkg.sv
// Package: shared types for the clock victim selector.
// Assumes: nothing beyond IEEE 1800-2017.
package cvs_pkg;
    typedef enum logic {
        SEL_IDLE = 1'b0,
        SEL_SCAN = 1'b1
    } sel_state_e;
endpackage

// File: rtl/cvs_refbits.sv
// Module: cvs_refbits
// Holds one "recently used" flag per frame.
// A reference or a victim mark raises a flag, and a walk clearing
// the hand frame drops it. Raising wins over clearing.
// Assumes: set_hot and hand_hot are at most one-hot.
module cvs_refbits #(
    parameter int NUM_FRAMES = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_FRAMES-1:0] set_hot,
    input  logic [NUM_FRAMES-1:0] hand_hot,
    input  logic                  clr_en,
    input  logic                  mark_en,
    output logic [NUM_FRAMES-1:0] used
);
    for (genvar i = 0; i < NUM_FRAMES; i++) begin : g_frame
        // Per-frame flag update: set has priority over clear.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                used[i] <= 1'b0;
            end else if (set_hot[i] || (mark_en && hand_hot[i])) begin
                used[i] <= 1'b1;
            end else if (clr_en && hand_hot[i]) begin
                used[i] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/cvs_hand.sv
// Module: cvs_hand
// Circular hand index over the frames. It advances by one when
// asked and wraps from the last frame to frame 0.
// Assumes: NUM_FRAMES >= 2.
module cvs_hand #(
    parameter int NUM_FRAMES = 8,
    localparam int IDX_W = $clog2(NUM_FRAMES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    output logic [IDX_W-1:0] hand
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_FRAMES - 1);

    // Hand register: step with wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hand <= '0;
        end else if (advance) begin
            hand <= (hand == LAST) ? '0 : hand + 1'b1;
        end
    end
endmodule

// File: rtl/cvs_ctrl.sv
// Module: cvs_ctrl
// Walk controller. It accepts a request when idle, then examines
// the hand frame once per cycle. A raised flag is cleared and the
// walk moves on. A clear flag ends the walk: the frame is marked,
// latched as the victim and granted for one cycle.
// Assumes: the flag of the hand frame is presented on hand_used.
module cvs_ctrl
    import cvs_pkg::*;
#(
    parameter int NUM_FRAMES = 8,
    localparam int IDX_W = $clog2(NUM_FRAMES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             repl_req,
    input  logic             hand_used,
    input  logic [IDX_W-1:0] hand,
    output logic             advance,
    output logic             clr_en,
    output logic             mark_en,
    output logic             busy,
    output logic             grant,
    output logic [IDX_W-1:0] victim
);
    sel_state_e state;
    logic       examine;

    // Decode the current step of the walk.
    always_comb begin
        examine = (state == SEL_SCAN);
        advance = examine;
        clr_en  = examine && hand_used;
        mark_en = examine && !hand_used;
        busy    = examine;
    end

    // State, grant pulse and victim latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= SEL_IDLE;
            grant  <= 1'b0;
            victim <= '0;
        end else begin
            grant <= 1'b0;
            case (state)
                SEL_IDLE: if (repl_req) state <= SEL_SCAN;
                SEL_SCAN: begin
                    if (!hand_used) begin
                        grant  <= 1'b1;
                        victim <= hand;
                        state  <= SEL_IDLE;
                    end
                end
                default: state <= SEL_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/clock_victim_sel.sv
// Module: clock_victim_sel (top)
// Second-chance victim selection over NUM_FRAMES frames. It wires
// the flag array, the hand and the walk controller, and decodes
// the reference and hand indices to one-hot.
// Assumes: references to indices >= NUM_FRAMES are dropped.
module clock_victim_sel #(
    parameter int NUM_FRAMES = 8,
    localparam int IDX_W = $clog2(NUM_FRAMES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_valid,
    input  logic [IDX_W-1:0] ref_frame,
    input  logic             repl_req,
    output logic             repl_busy,
    output logic             repl_grant,
    output logic [IDX_W-1:0] victim_frame
);
    logic [NUM_FRAMES-1:0] frame_used;
    logic [NUM_FRAMES-1:0] ref_hot;
    logic [NUM_FRAMES-1:0] hand_hot;
    logic [IDX_W-1:0]      hand_idx;
    logic                  hand_used;
    logic                  advance;
    logic                  clr_en;
    logic                  mark_en;

    for (genvar i = 0; i < NUM_FRAMES; i++) begin : g_dec
        assign ref_hot[i]  = ref_valid && (ref_frame == IDX_W'(i));
        assign hand_hot[i] = (hand_idx == IDX_W'(i));
    end

    assign hand_used = |(frame_used & hand_hot);

    cvs_refbits #(.NUM_FRAMES(NUM_FRAMES)) u_bits (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_hot  (ref_hot),
        .hand_hot (hand_hot),
        .clr_en   (clr_en),
        .mark_en  (mark_en),
        .used     (frame_used)
    );

    cvs_hand #(.NUM_FRAMES(NUM_FRAMES)) u_hand (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (advance),
        .hand    (hand_idx)
    );

    cvs_ctrl #(.NUM_FRAMES(NUM_FRAMES)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .repl_req  (repl_req),
        .hand_used (hand_used),
        .hand      (hand_idx),
        .advance   (advance),
        .clr_en    (clr_en),
        .mark_en   (mark_en),
        .busy      (repl_busy),
        .grant     (repl_grant),
        .victim    (victim_frame)
    );
endmodule

// File: rtl/clock_victim_sel_chk.sv
// Module: clock_victim_sel_chk
// Property checker bound into clock_victim_sel. It observes the
// ports plus the flag vector and the hand index.
module clock_victim_sel_chk #(
    parameter int NUM_FRAMES = 8,
    localparam int IDX_W = $clog2(NUM_FRAMES),
    localparam int CW = $clog2(NUM_FRAMES + 2) + 1
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  ref_valid,
    input logic [IDX_W-1:0]      ref_frame,
    input logic                  repl_req,
    input logic                  repl_busy,
    input logic                  repl_grant,
    input logic [IDX_W-1:0]      victim_frame,
    input logic [NUM_FRAMES-1:0] frame_used,
    input logic [IDX_W-1:0]      hand_idx
);
    logic [CW-1:0]         busy_cnt;
    logic [NUM_FRAMES-1:0] used_q;

    function automatic logic [IDX_W-1:0] after(input logic [IDX_W-1:0] f);
        return (int'(f) == NUM_FRAMES - 1) ? '0 : f + 1'b1;
    endfunction

    // Count consecutive busy cycles and keep last cycle's flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_cnt <= '0;
            used_q   <= '0;
        end else begin
            busy_cnt <= repl_busy ? busy_cnt + 1'b1 : '0;
            used_q   <= frame_used;
        end
    end

    // R2 R8
    ref_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_valid && (int'(ref_frame) < NUM_FRAMES)) |=> frame_used[$past(ref_frame)]);

    // R9
    grant_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        repl_grant |=> !repl_grant);

    // R9
    grant_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(repl_grant && repl_busy));

    // R9
    req_starts_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (repl_req && !repl_busy) |=> repl_busy);

    // R5
    walk_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        repl_busy |-> (int'(busy_cnt) <= NUM_FRAMES));

    // R4
    victim_was_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        repl_grant |-> !used_q[victim_frame]);

    // R7
    victim_marked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        repl_grant |-> frame_used[victim_frame]);

    // R6
    hand_after_victim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        repl_grant |-> (hand_idx == after(victim_frame)));
endmodule

bind clock_victim_sel clock_victim_sel_chk #(.NUM_FRAMES(NUM_FRAMES)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ref_valid    (ref_valid),
    .ref_frame    (ref_frame),
    .repl_req     (repl_req),
    .repl_busy    (repl_busy),
    .repl_grant   (repl_grant),
    .victim_frame (victim_frame),
    .frame_used   (frame_used),
    .hand_idx     (hand_idx)
);

// File: tb/clock_victim_sel_test.sv
// Bench: sweeps every flag pattern of a 4-frame selector as the
// hand drifts. An arithmetic model of the walk predicts each
// victim and latency.
module clock_victim_sel_test;
    localparam int N = 4;
    localparam int W = $clog2(N);

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ref_valid = 1'b0;
    logic [W-1:0] ref_frame = '0;
    logic         repl_req = 1'b0;
    logic         repl_busy;
    logic         repl_grant;
    logic [W-1:0] victim_frame;

    int     checks = 0;
    int     bad = 0;
    bit     model_used [N];
    int     model_hand = 0;
    longint cyc = 0;

    clock_victim_sel #(.NUM_FRAMES(N)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .ref_valid    (ref_valid),
        .ref_frame    (ref_frame),
        .repl_req     (repl_req),
        .repl_busy    (repl_busy),
        .repl_grant   (repl_grant),
        .victim_frame (victim_frame)
    );

    always #2 clk = ~clk;

    // Watchdog: a hung run is counted as a failure.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            bad++;
            checks++;
            $display("FAIL watchdog: actual=%0d cycles expected<=100000", cyc);
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One-cycle reference, issued and left at a negedge.
    task automatic do_ref(input int f);
        ref_valid = 1'b1;
        ref_frame = W'(f);
        @(negedge clk);
        ref_valid = 1'b0;
        model_used[f] = 1'b1;
    endtask

    // Request a victim and check it against the model.
    task automatic do_request(input string tag);
        int k = 0;
        int h = model_hand;
        int cnt = 0;
        while (model_used[h] && k < N) begin
            model_used[h] = 1'b0;
            h = (h + 1) % N;
            k++;
        end
        model_used[h] = 1'b1;
        model_hand = (h + 1) % N;
        repl_req = 1'b1;
        @(negedge clk);
        repl_req = 1'b0;
        check(repl_busy === 1'b1, {tag, " R9 busy after request"}, int'(repl_busy), 1);
        while (!repl_grant && cnt < 3 * N) begin
            @(negedge clk);
            cnt++;
        end
        check(cnt == k + 1, {tag, " R5 latency"}, cnt, k + 1);
        check(int'(victim_frame) == h, {tag, " R4 R3 R6 victim"}, int'(victim_frame), h);
        check(repl_busy === 1'b0, {tag, " R9 busy low at grant"}, int'(repl_busy), 0);
        @(negedge clk);
        check(repl_grant === 1'b0, {tag, " R9 grant single pulse"}, int'(repl_grant), 0);
    endtask

    initial begin
        int h0;
        int cnt;
        bit extra;
        for (int i = 0; i < N; i++) model_used[i] = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check(repl_busy === 1'b0, "R1 busy after reset", int'(repl_busy), 0);
        check(repl_grant === 1'b0, "R1 grant after reset", int'(repl_grant), 0);
        check(victim_frame === '0, "R1 victim after reset", int'(victim_frame), 0);
        do_request("R1 first");

        // R2 R3 R4 R5 R6 R7: every flag pattern, four hand drifts
        for (int rep = 0; rep < 4; rep++) begin
            for (int pat = 0; pat < (1 << N); pat++) begin
                for (int f = 0; f < N; f++) if (pat[f]) do_ref(f);
                do_request("R2 sweep");
            end
        end

        // R5 longest walk: every flag raised, victim is the start frame
        for (int f = 0; f < N; f++) do_ref(f);
        do_request("R5 full walk");

        // R8 collision: reference the second examined frame in its clear cycle
        for (int f = 0; f < N; f++) do_ref(f);
        h0 = model_hand;
        repl_req = 1'b1;
        @(negedge clk);
        repl_req = 1'b0;
        cnt = 0;
        @(negedge clk);
        cnt++;
        ref_valid = 1'b1;
        ref_frame = W'((h0 + 1) % N);
        repl_req = 1'b1;            // R9 request while busy
        @(negedge clk);
        cnt++;
        ref_valid = 1'b0;
        repl_req = 1'b0;
        while (!repl_grant && cnt < 3 * N) begin
            @(negedge clk);
            cnt++;
        end
        check(cnt == N + 1, "R8 collision walk latency", cnt, N + 1);
        check(int'(victim_frame) == h0, "R8 collision victim", int'(victim_frame), h0);
        for (int i = 0; i < N; i++) model_used[i] = 1'b0;
        model_used[h0] = 1'b1;
        model_used[(h0 + 1) % N] = 1'b1;
        model_hand = (h0 + 1) % N;
        // R9: the request made while busy must not start a walk
        extra = 1'b0;
        for (int i = 0; i < N + 3; i++) begin
            @(negedge clk);
            if (repl_grant || repl_busy) extra = 1'b1;
        end
        check(!extra, "R9 request while busy ignored", int'(extra), 0);
        // R8: the kept flag makes the walk skip that frame
        do_request("R8 kept flag");

        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule